// File: doc/BRIEF.md
# Code Segment Descriptor Checker

This block decides whether a candidate code segment descriptor may become the new code segment during a far control transfer. It receives the already decoded descriptor fields together with the raw selector, the requested and current privilege levels and a flag telling whether long mode is active. On a start strobe it evaluates every rule in a fixed priority order and registers a verdict: pass, or a fault with either the general protection vector or the not-present vector and an error code derived from the selector.

The verdict appears one clock after the strobe, marked by a one-cycle done pulse. The fault, vector select and error code then hold their values until the next strobe, so the surrounding control logic can sample them at any later cycle. Only the first failing rule in priority order is reported. Table fetch, gates, stack switching and the register load itself belong to other blocks.

Top module: `cs_desc_check`

## Requirements
- R1: After reset, done, fault, vec_np and err_code are all 0.
- R2: done is 1 in exactly the cycle after a cycle with start=1, and 0 in every other cycle.
- R3: A descriptor with d_valid=0, with d_s=0 (system descriptor), or with d_type[3]=0 (data segment) yields fault=1, vec_np=0.
- R4: With d_l=1, d_db=1 and long_mode=1 the result is fault=1, vec_np=0; with long_mode=0 the L/D combination causes no fault.
- R5: For a non-conforming code segment (d_type[2]=0), d_dpl different from cur_pl yields fault=1, vec_np=0.
- R6: For a non-conforming code segment, req_pl greater than cur_pl yields fault=1, vec_np=0; req_pl=0 never fails this rule.
- R7: For a conforming code segment (d_type[2]=1), d_dpl greater than cur_pl yields fault=1, vec_np=0; req_pl has no effect and d_dpl at or below cur_pl passes.
- R8: d_present=0 yields fault=1 with vec_np=1 (not-present) only when every earlier rule passes; if any earlier rule fails, vec_np=0.
- R9: On a fault, err_code equals sel with bits 1:0 cleared; on a pass, err_code is 0 and fault is 0.
- R10: fault, vec_np and err_code keep their values in every cycle not preceded by a start, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluate the presented descriptor |
| sel | input | 16 | Raw selector of the target segment |
| d_valid | input | 1 | Descriptor was fetched and is valid |
| d_s | input | 1 | 1 = code/data descriptor, 0 = system |
| d_type | input | 4 | Type field; bit 3 = code, bit 2 = conforming |
| d_dpl | input | 2 | Descriptor privilege level |
| d_present | input | 1 | Segment present |
| d_l | input | 1 | 64-bit code flag |
| d_db | input | 1 | Default operand size flag |
| req_pl | input | 2 | Requested privilege level to check (0 disables) |
| cur_pl | input | 2 | Current privilege level |
| long_mode | input | 1 | Long mode active |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Result is a fault |
| vec_np | output | 1 | 0 = general protection, 1 = not present |
| err_code | output | 16 | Error code for the fault |

## Verification
A wrong priority decision inside the block shows up at the ports as a not-present vector where a protection fault was due, or the reverse, in the very cycle the done pulse appears. A corrupted result register shows as an output that changes between strobes, visible one cycle after the disturbing input change. Random descriptors with a biased field mix reach every rule, and directed cases pin the boundaries where privilege levels are equal and where a present bit is clear behind an earlier failure.

// File: rtl/cs_desc_check.sv
module cs_desc_check (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] sel,
  input  logic        d_valid,
  input  logic        d_s,
  input  logic [3:0]  d_type,
  input  logic [1:0]  d_dpl,
  input  logic        d_present,
  input  logic        d_l,
  input  logic        d_db,
  input  logic [1:0]  req_pl,
  input  logic [1:0]  cur_pl,
  input  logic        long_mode,
  output logic        done,
  output logic        fault,
  output logic        vec_np,
  output logic [15:0] err_code
);

  logic is_code, conforming;
  logic bad_kind, bad_mode, bad_priv, gp_hit, np_hit;

  assign is_code    = d_type[3];
  assign conforming = d_type[2];

  assign bad_kind = !d_valid || !d_s || !is_code;
  assign bad_mode = d_l && long_mode && d_db;
  assign bad_priv = conforming ? (d_dpl > cur_pl)
                               : ((d_dpl != cur_pl) || (req_pl > cur_pl));

  assign gp_hit = bad_kind || bad_mode || bad_priv;
  assign np_hit = !gp_hit && !d_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      fault    <= 1'b0;
      vec_np   <= 1'b0;
      err_code <= 16'h0000;
    end else begin
      done <= start;
      if (start) begin
        fault    <= gp_hit || np_hit;
        vec_np   <= np_hit;
        err_code <= (gp_hit || np_hit) ? {sel[15:2], 2'b00} : 16'h0000;
      end
    end
  end

endmodule

module cs_desc_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] sel,
  input logic [3:0]  d_type,
  input logic        d_present,
  input logic        done,
  input logic        fault,
  input logic        vec_np,
  input logic [15:0] err_code
);

  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r2_done_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  a_r3_data_is_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !d_type[3]) |=> (fault && !vec_np));

  a_r8_np_needs_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (done && vec_np) |-> (fault && !$past(d_present)));

  a_r9_err_matches_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (err_code == ($past(sel) & 16'hfffc)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> ($stable(fault) && $stable(vec_np) && $stable(err_code)));

endmodule

bind cs_desc_check cs_desc_check_sva i_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .d_type(d_type),
  .d_present(d_present), .done(done), .fault(fault), .vec_np(vec_np),
  .err_code(err_code)
);

// File: tb/test_cs_desc_check.sv
module test_cs_desc_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] sel = '0;
  logic d_valid = 1'b0, d_s = 1'b0, d_present = 1'b0, d_l = 1'b0, d_db = 1'b0, long_mode = 1'b0;
  logic [3:0] d_type = '0;
  logic [1:0] d_dpl = '0, req_pl = '0, cur_pl = '0;
  logic done, fault, vec_np;
  logic [15:0] err_code;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  cs_desc_check i_cs_desc_check (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .d_valid(d_valid),
    .d_s(d_s), .d_type(d_type), .d_dpl(d_dpl), .d_present(d_present),
    .d_l(d_l), .d_db(d_db), .req_pl(req_pl), .cur_pl(cur_pl),
    .long_mode(long_mode), .done(done), .fault(fault), .vec_np(vec_np),
    .err_code(err_code)
  );

  // returns {fault, vec_np}
  function automatic logic [1:0] expect_res(
    input logic v, input logic s, input logic [3:0] t, input logic [1:0] dpl,
    input logic p, input logic l, input logic db, input logic [1:0] rpl,
    input logic [1:0] cpl, input logic lm);
    if (!v || !s || !t[3]) return 2'b10;
    if (l && lm && db) return 2'b10;
    if (t[2]) begin
      if (dpl > cpl) return 2'b10;
    end else begin
      if (dpl != cpl) return 2'b10;
      if (rpl > cpl) return 2'b10;
    end
    if (!p) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input string req, input logic [15:0] s_sel, input logic v, input logic s,
                         input logic [3:0] t, input logic [1:0] dpl, input logic p, input logic l,
                         input logic db, input logic [1:0] rpl, input logic [1:0] cpl, input logic lm);
    logic [1:0] e;
    logic [15:0] ee;
    e  = expect_res(v, s, t, dpl, p, l, db, rpl, cpl, lm);
    ee = e[1] ? (s_sel & 16'hfffc) : 16'h0000;
    @(negedge clk);
    sel = s_sel; d_valid = v; d_s = s; d_type = t; d_dpl = dpl; d_present = p;
    d_l = l; d_db = db; req_pl = rpl; cur_pl = cpl; long_mode = lm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " done"}, {31'd0, done}, 32'd1);
    check({req, " fault/vec"}, {30'd0, fault, vec_np}, {30'd0, e});
    check({req, " R9 err_code"}, {16'd0, err_code}, {16'd0, ee});
    sel = ~s_sel; d_valid = ~v; d_present = ~p; d_type = ~t; cur_pl = ~cpl;
    @(negedge clk);
    check("R2 done low", {31'd0, done}, 32'd0);
    check("R10 hold", {14'd0, fault, vec_np, err_code}, {14'd0, e, ee});
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset", {13'd0, done, fault, vec_np, err_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {13'd0, done, fault, vec_np, err_code}, 32'd0);

    // sel, v, s, type, dpl, p, l, db, rpl, cpl, lm
    run_one("R9 pass",        16'h1237, 1, 1, 4'b1010, 2'd3, 1, 0, 0, 2'd3, 2'd3, 0);
    run_one("R3 invalid",     16'hbeef, 0, 1, 4'b1010, 2'd0, 1, 0, 0, 2'd0, 2'd0, 0);
    run_one("R3 system",      16'h0013, 1, 0, 4'b1010, 2'd0, 1, 0, 0, 2'd0, 2'd0, 0);
    run_one("R3 data",        16'h002b, 1, 1, 4'b0010, 2'd0, 1, 0, 0, 2'd0, 2'd0, 0);
    run_one("R4 L+D in lm",   16'h0008, 1, 1, 4'b1010, 2'd0, 1, 1, 1, 2'd0, 2'd0, 1);
    run_one("R4 L+D no lm",   16'h0008, 1, 1, 4'b1010, 2'd0, 1, 1, 1, 2'd0, 2'd0, 0);
    run_one("R5 dpl<cpl",     16'h0010, 1, 1, 4'b1010, 2'd1, 1, 0, 0, 2'd0, 2'd2, 0);
    run_one("R5 dpl>cpl",     16'h0011, 1, 1, 4'b1000, 2'd3, 1, 0, 0, 2'd0, 2'd2, 0);
    run_one("R6 rpl>cpl",     16'h0022, 1, 1, 4'b1010, 2'd1, 1, 0, 0, 2'd2, 2'd1, 0);
    run_one("R6 rpl zero",    16'h0020, 1, 1, 4'b1010, 2'd3, 1, 0, 0, 2'd0, 2'd3, 0);
    run_one("R7 conf dpl>cpl",16'h0033, 1, 1, 4'b1110, 2'd2, 1, 0, 0, 2'd0, 2'd1, 0);
    run_one("R7 conf ok",     16'h0033, 1, 1, 4'b1110, 2'd0, 1, 0, 0, 2'd3, 2'd2, 0);
    run_one("R8 not present", 16'h4567, 1, 1, 4'b1010, 2'd0, 0, 0, 0, 2'd0, 2'd0, 0);
    run_one("R8 gp over np",  16'h4567, 1, 1, 4'b1010, 2'd1, 0, 0, 0, 2'd0, 2'd0, 0);
    run_one("R8 data over np",16'h4567, 1, 1, 4'b0110, 2'd0, 0, 0, 0, 2'd0, 2'd0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      logic [15:0] rs;
      r  = $urandom;
      rs = 16'($urandom);
      run_one("R3-R9 random", rs, (r[3:0] != 0), (r[7:4] != 0),
              {(r[11:8] != 0), r[12], r[13], r[14]}, r[16:15], (r[19:17] != 0),
              r[20], r[21], (r[24] ? r[23:22] : 2'd0), r[26:25], r[27]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule